// File: doc/BRIEF.md
# Dual-Clock Burst-Addressed Shared Memory

This block is a shared memory with two fully independent access ports. Each port has its own clock and its own reset, and either port can read or write any word at any time. A word is 72 bits wide and is divided into eight 9-bit lanes. Every lane can be written or read on its own. Each port captures its selects, write flag, lane enables and write data in input registers on its clock edge. The word that the port accesses is held in a per-port burst address register. That register can take a new address, advance by one, or jump back to the address it last took.

The output of each port can be chosen, statically, to run in one of two modes. In flow-through mode the read data appears in the same cycle as the access. In pipelined mode it passes through one more register stage, so selects and lane enables take effect at the output one edge later than in flow-through mode. A port can be put to sleep, which stops it from reacting to its dynamic inputs. Each port also raises a one-cycle collision flag when both ports reach the same word in the same cycle and at least one of them is writing. Both clocks must be the same clock for that comparison to be meaningful.

The storage is a small, parameterised array of 2^AW words.

Top module: `dpr_burst_ram`

## Requirements
- R1: After reset both read buses and both collision flags are zero, and both burst address registers hold address 0.
- R2: A write updates only the lanes whose enable bit is set; lane i occupies data bits 9i+8 down to 9i and is controlled by enable bit i. A read returns zero in every lane whose enable is clear.
- R3: A read captured at edge N shows its data from just after edge N in flow-through mode (pipe input 0). In pipelined mode (pipe input 1) the data shows from just after edge N+1. A write captured at edge N is in the array from edge N+1, so a read captured at edge N+1 returns the new data.
- R4: A port accesses the array only when its active-low select is 0 and its active-high select is 1 at the capturing edge. In any other case a write changes nothing and the read bus is zero.
- R5: A load input of 1 at an edge places the external address in the burst register and also stores it as the port's anchor address.
- R6: A step input of 1 (without load or rewind) advances the burst register by one per edge, wrapping from 2^AW-1 to 0.
- R7: A rewind input of 1 (without load) returns the burst register to the anchor address. The priority order is load, then rewind, then step, then hold. The anchor changes only on a load.
- R8: In pipelined mode, a deselect or a change of lane enables captured at edge N first changes the read bus after edge N+1. The output after edge N still reflects the previous access.
- R9: At an edge where sleep is 1, the port performs no access and its burst and anchor registers hold, whatever the other dynamic inputs are. The pipe select still acts while the port sleeps.
- R10: The output enable only forces the port's read bus to zero and does not alter array contents, addresses or pipeline state.
- R11: Data written through either port is readable through both ports.
- R12: The collision flag of each port is 1 for exactly the cycle after a cycle in which both ports accessed the same word with at least one write. Two reads of the same word leave it at 0.
- R13: Writes from both ports to disjoint lanes of the same word in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| pipe_a | input | 1 | Port A output mode, 1 = pipelined |
| sleep_a | input | 1 | Port A sleep |
| cs_n_a | input | 1 | Port A active-low select |
| cs_a | input | 1 | Port A active-high select |
| wr_a | input | 1 | Port A write (1) or read (0) |
| oe_a | input | 1 | Port A read bus enable |
| load_a | input | 1 | Port A take external address |
| step_a | input | 1 | Port A advance burst address |
| rewind_a | input | 1 | Port A return to anchor address |
| addr_a | input | AW | Port A external address |
| lanes_a | input | LANES | Port A lane enables |
| wdata_a | input | LANES*LW | Port A write data |
| rdata_a | output | LANES*LW | Port A read data |
| coll_a | output | 1 | Port A collision flag |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| pipe_b | input | 1 | Port B output mode, 1 = pipelined |
| sleep_b | input | 1 | Port B sleep |
| cs_n_b | input | 1 | Port B active-low select |
| cs_b | input | 1 | Port B active-high select |
| wr_b | input | 1 | Port B write (1) or read (0) |
| oe_b | input | 1 | Port B read bus enable |
| load_b | input | 1 | Port B take external address |
| step_b | input | 1 | Port B advance burst address |
| rewind_b | input | 1 | Port B return to anchor address |
| addr_b | input | AW | Port B external address |
| lanes_b | input | LANES | Port B lane enables |
| wdata_b | input | LANES*LW | Port B write data |
| rdata_b | output | LANES*LW | Port B read data |
| coll_b | output | 1 | Port B collision flag |

## Verification
The bench drives inputs half a period before the capturing edge and samples outputs half a period after that edge. A flow-through read is therefore checked in the very cycle it was captured. A pipelined read is checked one sample later, and the sample in between is checked to still show the previous access. Written data is expected in a read captured one edge after the write. The reference model therefore applies each cycle's writes only after that cycle's reads have been compared. The collision flag is checked one sample after the colliding cycle, and checked again one sample later to confirm it has dropped.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_STEP   = 2'd1,
        OP_REWIND = 2'd2,
        OP_LOAD   = 2'd3
    } ctr_op_e;

    typedef struct packed {
        logic acc;
        logic wr;
    } acc_kind_t;

    function automatic ctr_op_e pick_op(input logic frozen, input logic load,
                                        input logic rewind, input logic step);
        if (frozen)      return OP_HOLD;
        else if (load)   return OP_LOAD;
        else if (rewind) return OP_REWIND;
        else if (step)   return OP_STEP;
        else             return OP_HOLD;
    endfunction

    function automatic logic hits(input acc_kind_t me, input acc_kind_t peer,
                                  input logic same_word);
        return me.acc && peer.acc && (me.wr || peer.wr) && same_word;
    endfunction

endpackage

// File: rtl/dpr_burst_ctr.sv
module dpr_burst_ctr
    import dpr_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frozen,
    input  logic          load,
    input  logic          rewind,
    input  logic          step,
    input  logic [AW-1:0] ext,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] anchor
);

    ctr_op_e op;

    always_comb op = pick_op(frozen, load, rewind, step);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            anchor <= '0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    cur    <= ext;
                    anchor <= ext;
                end
                OP_REWIND: cur <= anchor;
                OP_STEP:   cur <= cur + 1'b1;
                default:   cur <= cur;
            endcase
        end
    end

    a_r5_load_takes_addr: assert property (@(posedge clk) disable iff (rst)
        (!frozen && load) |=> (cur == $past(ext) && anchor == $past(ext)));

    a_r7_anchor_only_on_load: assert property (@(posedge clk) disable iff (rst)
        (frozen || !load) |=> $stable(anchor));

    a_r6_step_wraps: assert property (@(posedge clk) disable iff (rst)
        (!frozen && !load && !rewind && step) |=> cur == AW'($past(cur) + 1'b1));

endmodule

// File: rtl/dpr_xor_bank.sv
module dpr_xor_bank #(
    parameter int AW    = 6,
    parameter int LANES = 8,
    parameter int LW    = 9,
    localparam int DW    = LANES * LW,
    localparam int DEPTH = 1 << AW
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [LANES-1:0] wlanes,
    input  logic [DW-1:0]    wword,
    input  logic [AW-1:0]    raddr0,
    input  logic [AW-1:0]    raddr1,
    input  logic [AW-1:0]    raddr2,
    output logic [DW-1:0]    rword0,
    output logic [DW-1:0]    rword1,
    output logic [DW-1:0]    rword2
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wlanes[g]) lane_mem[waddr] <= wword[g*LW +: LW];
        end

        assign rword0[g*LW +: LW] = lane_mem[raddr0];
        assign rword1[g*LW +: LW] = lane_mem[raddr1];
        assign rword2[g*LW +: LW] = lane_mem[raddr2];
    end

endmodule

// File: rtl/dpr_port.sv
module dpr_port
    import dpr_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 8,
    parameter int LW    = 9,
    localparam int DW   = LANES * LW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pipe,
    input  logic             sleep,
    input  logic             cs_n,
    input  logic             cs,
    input  logic             wr,
    input  logic             oe,
    input  logic             load,
    input  logic             step,
    input  logic             rewind,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] lanes,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    rd_word,
    input  acc_kind_t        peer,
    input  logic [AW-1:0]    peer_addr,
    output acc_kind_t        kind,
    output logic [AW-1:0]    cur,
    output logic [LANES-1:0] lanes_q,
    output logic [DW-1:0]    wdata_q,
    output logic [DW-1:0]    rdata,
    output logic             coll
);

    acc_kind_t     kind_q;
    logic          picked;
    logic [AW-1:0] anchor;
    logic [DW-1:0] flow_word;
    logic [DW-1:0] pipe_word;

    assign picked = !cs_n && cs;

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q  <= '0;
            lanes_q <= '0;
            wdata_q <= '0;
        end else if (sleep) begin
            kind_q.acc <= 1'b0;
        end else begin
            kind_q.acc <= picked;
            kind_q.wr  <= wr;
            lanes_q    <= lanes;
            wdata_q    <= wdata;
        end
    end

    dpr_burst_ctr #(.AW(AW)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .frozen (sleep),
        .load   (load),
        .rewind (rewind),
        .step   (step),
        .ext    (addr),
        .cur    (cur),
        .anchor (anchor)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_rmask
        assign flow_word[g*LW +: LW] =
            (kind_q.acc && !kind_q.wr && lanes_q[g]) ? rd_word[g*LW +: LW] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_word <= '0;
        else     pipe_word <= flow_word;
    end

    always_ff @(posedge clk) begin
        if (rst) coll <= 1'b0;
        else     coll <= hits(kind_q, peer, cur == peer_addr);
    end

    assign rdata = oe ? (pipe ? pipe_word : flow_word) : '0;
    assign kind  = kind_q;

    a_r9_sleep_freezes: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(cur) && $stable(anchor) && !kind_q.acc));

    a_r12_coll_needs_access: assert property (@(posedge clk) disable iff (rst)
        coll |-> $past(kind_q.acc));

    a_r10_oe_gates: assert property (@(posedge clk) disable iff (rst)
        !oe |-> rdata == '0);

    a_r4_flow_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!pipe && !kind_q.acc) |-> rdata == '0);

endmodule

// File: rtl/dpr_burst_ram.sv
module dpr_burst_ram
    import dpr_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 8,
    parameter int LW    = 9,
    localparam int DW   = LANES * LW
) (
    input  logic             clk_a,
    input  logic             rst_a,
    input  logic             pipe_a,
    input  logic             sleep_a,
    input  logic             cs_n_a,
    input  logic             cs_a,
    input  logic             wr_a,
    input  logic             oe_a,
    input  logic             load_a,
    input  logic             step_a,
    input  logic             rewind_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [LANES-1:0] lanes_a,
    input  logic [DW-1:0]    wdata_a,
    output logic [DW-1:0]    rdata_a,
    output logic             coll_a,
    input  logic             clk_b,
    input  logic             rst_b,
    input  logic             pipe_b,
    input  logic             sleep_b,
    input  logic             cs_n_b,
    input  logic             cs_b,
    input  logic             wr_b,
    input  logic             oe_b,
    input  logic             load_b,
    input  logic             step_b,
    input  logic             rewind_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [LANES-1:0] lanes_b,
    input  logic [DW-1:0]    wdata_b,
    output logic [DW-1:0]    rdata_b,
    output logic             coll_b
);

    acc_kind_t        kind_a, kind_b;
    logic [AW-1:0]    cur_a, cur_b;
    logic [LANES-1:0] lq_a, lq_b;
    logic [DW-1:0]    wq_a, wq_b;
    logic [DW-1:0]    word_a, word_b;
    logic [DW-1:0]    ba_r0, ba_r1, ba_r2;
    logic [DW-1:0]    bb_r0, bb_r1, bb_r2;

    // Each bank has one writer; a word's value is the XOR of both banks.
    assign word_a = ba_r0 ^ bb_r0;
    assign word_b = ba_r1 ^ bb_r1;

    dpr_port #(.AW(AW), .LANES(LANES), .LW(LW)) u_port_a (
        .clk(clk_a), .rst(rst_a), .pipe(pipe_a), .sleep(sleep_a),
        .cs_n(cs_n_a), .cs(cs_a), .wr(wr_a), .oe(oe_a),
        .load(load_a), .step(step_a), .rewind(rewind_a),
        .addr(addr_a), .lanes(lanes_a), .wdata(wdata_a),
        .rd_word(word_a), .peer(kind_b), .peer_addr(cur_b),
        .kind(kind_a), .cur(cur_a), .lanes_q(lq_a), .wdata_q(wq_a),
        .rdata(rdata_a), .coll(coll_a)
    );

    dpr_port #(.AW(AW), .LANES(LANES), .LW(LW)) u_port_b (
        .clk(clk_b), .rst(rst_b), .pipe(pipe_b), .sleep(sleep_b),
        .cs_n(cs_n_b), .cs(cs_b), .wr(wr_b), .oe(oe_b),
        .load(load_b), .step(step_b), .rewind(rewind_b),
        .addr(addr_b), .lanes(lanes_b), .wdata(wdata_b),
        .rd_word(word_b), .peer(kind_a), .peer_addr(cur_a),
        .kind(kind_b), .cur(cur_b), .lanes_q(lq_b), .wdata_q(wq_b),
        .rdata(rdata_b), .coll(coll_b)
    );

    dpr_xor_bank #(.AW(AW), .LANES(LANES), .LW(LW)) u_bank_a (
        .clk(clk_a), .we(kind_a.acc && kind_a.wr), .waddr(cur_a),
        .wlanes(lq_a), .wword(wq_a ^ bb_r2),
        .raddr0(cur_a), .raddr1(cur_b), .raddr2(cur_b),
        .rword0(ba_r0), .rword1(ba_r1), .rword2(ba_r2)
    );

    dpr_xor_bank #(.AW(AW), .LANES(LANES), .LW(LW)) u_bank_b (
        .clk(clk_b), .we(kind_b.acc && kind_b.wr), .waddr(cur_b),
        .wlanes(lq_b), .wword(wq_b ^ ba_r2),
        .raddr0(cur_a), .raddr1(cur_b), .raddr2(cur_a),
        .rword0(bb_r0), .rword1(bb_r1), .rword2(bb_r2)
    );

    a_r1_reset_quiet_a: assert property (@(posedge clk_a)
        $past(rst_a) |-> (!coll_a && rdata_a == '0));

endmodule

// File: tb/sim_dpr_burst_ram.sv
module sim_dpr_burst_ram;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic a_pipe = 0, a_slp = 0, a_cn = 1, a_c = 0, a_w = 0, a_oe = 1, a_l = 0, a_s = 0, a_r = 0;
    logic b_pipe = 0, b_slp = 0, b_cn = 1, b_c = 0, b_w = 0, b_oe = 1, b_l = 0, b_s = 0, b_r = 0;
    logic [5:0]  a_ad = 0, b_ad = 0;
    logic [7:0]  a_ln = 0, b_ln = 0;
    logic [71:0] a_d = 0, b_d = 0;
    logic [71:0] rdata_a, rdata_b;
    logic        coll_a, coll_b;

    logic [71:0] refm [64];
    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    dpr_burst_ram u0 (
        .clk_a(clk), .rst_a(rst), .pipe_a(a_pipe), .sleep_a(a_slp),
        .cs_n_a(a_cn), .cs_a(a_c), .wr_a(a_w), .oe_a(a_oe),
        .load_a(a_l), .step_a(a_s), .rewind_a(a_r),
        .addr_a(a_ad), .lanes_a(a_ln), .wdata_a(a_d),
        .rdata_a(rdata_a), .coll_a(coll_a),
        .clk_b(clk), .rst_b(rst), .pipe_b(b_pipe), .sleep_b(b_slp),
        .cs_n_b(b_cn), .cs_b(b_c), .wr_b(b_w), .oe_b(b_oe),
        .load_b(b_l), .step_b(b_s), .rewind_b(b_r),
        .addr_b(b_ad), .lanes_b(b_ln), .wdata_b(b_d),
        .rdata_b(rdata_b), .coll_b(coll_b)
    );

    function automatic logic [71:0] pat(int a, int s);
        logic [71:0] w;
        for (int i = 0; i < 8; i++) w[i*9 +: 9] = 9'((a * 37 + s * 11 + i * 5) ^ (i << 6));
        return w;
    endfunction

    function automatic logic [71:0] msk(logic [71:0] w, logic [7:0] ln);
        logic [71:0] o;
        for (int i = 0; i < 8; i++) o[i*9 +: 9] = ln[i] ? w[i*9 +: 9] : 9'd0;
        return o;
    endfunction

    function automatic logic [71:0] mrg(logic [71:0] old, logic [71:0] nw, logic [7:0] ln);
        return msk(nw, ln) | msk(old, ~ln);
    endfunction

    task automatic chk(string tag, logic [71:0] act, logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pa(logic cn, logic c, logic w, logic l, logic s, logic r,
                      logic [5:0] ad, logic [7:0] ln, logic [71:0] d);
        a_cn = cn; a_c = c; a_w = w; a_l = l; a_s = s; a_r = r; a_ad = ad; a_ln = ln; a_d = d;
    endtask

    task automatic pb(logic cn, logic c, logic w, logic l, logic s, logic r,
                      logic [5:0] ad, logic [7:0] ln, logic [71:0] d);
        b_cn = cn; b_c = c; b_w = w; b_l = l; b_s = s; b_r = r; b_ad = ad; b_ln = ln; b_d = d;
    endtask

    task automatic ia(); pa(1, 0, 0, 0, 0, 0, 6'd0, 8'd0, 72'd0); endtask
    task automatic ib(); pb(1, 0, 0, 0, 0, 0, 6'd0, 8'd0, 72'd0); endtask

    task automatic wr_a(logic [5:0] ad, logic [7:0] ln, logic [71:0] d);
        pa(0, 1, 1, 1, 0, 0, ad, ln, d); ib(); tick();
        refm[ad] = mrg(refm[ad], d, ln);
    endtask

    task automatic rd_a(string tag, logic [5:0] ad, logic [7:0] ln);
        pa(0, 1, 0, 1, 0, 0, ad, ln, 72'd0); ib(); tick();
        chk(tag, rdata_a, msk(refm[ad], ln));
    endtask

    task automatic rd_b(string tag, logic [5:0] ad, logic [7:0] ln);
        ia(); pb(0, 1, 0, 1, 0, 0, ad, ln, 72'd0); tick();
        chk(tag, rdata_b, msk(refm[ad], ln));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [71:0] w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        ia(); ib();
        // R1: reset state
        chk("R1 rdata_a", rdata_a, 72'd0);
        chk("R1 rdata_b", rdata_b, 72'd0);
        chk("R1 coll", {70'd0, coll_a, coll_b}, 72'd0);
        // R1: burst register starts at 0: read with no load
        refm[0] = 72'd0;
        pa(0, 1, 1, 0, 0, 0, 6'd9, 8'hFF, pat(0, 1)); ib(); tick();
        refm[0] = pat(0, 1);
        rd_a("R1 start address", 6'd0, 8'hFF);

        // Fill the array with a burst: load then step, wrapping checked later
        for (int i = 0; i < 64; i++) begin
            pa(0, 1, 1, (i == 0), (i != 0), 0, 6'd0, 8'hFF, pat(i, 7));
            ib(); tick();
            refm[i] = pat(i, 7);
        end

        // R11: cross-port visibility
        wr_a(6'd5, 8'hFF, pat(5, 1));
        rd_b("R11 B sees A write", 6'd5, 8'hFF);
        ia(); pb(0, 1, 1, 1, 0, 0, 6'd6, 8'hFF, pat(6, 2)); tick();
        refm[6] = pat(6, 2);
        rd_a("R11 A sees B write", 6'd6, 8'hFF);

        // R2: lane writes and lane-masked reads
        wr_a(6'd5, 8'h0F, pat(5, 3));
        rd_a("R2 partial write", 6'd5, 8'hFF);
        rd_a("R2 masked read", 6'd5, 8'h81);

        // R4: select gating
        pa(1, 1, 1, 1, 0, 0, 6'd5, 8'hFF, pat(5, 9)); ib(); tick();
        pa(0, 0, 1, 1, 0, 0, 6'd5, 8'hFF, pat(5, 9)); ib(); tick();
        rd_a("R4 deselected writes ignored", 6'd5, 8'hFF);
        pa(1, 1, 0, 1, 0, 0, 6'd5, 8'hFF, 72'd0); ib(); tick();
        chk("R4 deselected read zero", rdata_a, 72'd0);

        // R5 R6: load then step with wrap
        rd_a("R5 load 62", 6'd62, 8'hFF);
        pa(0, 1, 0, 0, 1, 0, 6'd3, 8'hFF, 72'd0); ib(); tick();
        chk("R6 step to 63", rdata_a, refm[63]);
        pa(0, 1, 0, 0, 1, 0, 6'd3, 8'hFF, 72'd0); ib(); tick();
        chk("R6 wrap to 0", rdata_a, refm[0]);

        // R7: rewind and priority
        wr_a(6'd10, 8'hFF, pat(10, 4));
        wr_a(6'd11, 8'hFF, pat(11, 4));
        wr_a(6'd12, 8'hFF, pat(12, 4));
        wr_a(6'd20, 8'hFF, pat(20, 4));
        wr_a(6'd21, 8'hFF, pat(21, 4));
        wr_a(6'd30, 8'hFF, pat(30, 4));
        rd_a("R7 load 10", 6'd10, 8'hFF);
        pa(0, 1, 0, 0, 1, 0, 6'd0, 8'hFF, 72'd0); ib(); tick();
        pa(0, 1, 0, 0, 1, 0, 6'd0, 8'hFF, 72'd0); ib(); tick();
        chk("R7 stepped to 12", rdata_a, refm[12]);
        pa(0, 1, 0, 0, 0, 1, 6'd0, 8'hFF, 72'd0); ib(); tick();
        chk("R7 rewind to 10", rdata_a, refm[10]);
        pa(0, 1, 0, 1, 1, 1, 6'd20, 8'hFF, 72'd0); ib(); tick();
        chk("R7 load beats rewind", rdata_a, refm[20]);
        pa(0, 1, 0, 0, 1, 0, 6'd0, 8'hFF, 72'd0); ib(); tick();
        chk("R7 step to 21", rdata_a, refm[21]);
        pa(0, 1, 0, 0, 1, 1, 6'd0, 8'hFF, 72'd0); ib(); tick();
        chk("R7 rewind beats step", rdata_a, refm[20]);
        pa(0, 1, 0, 0, 0, 0, 6'd0, 8'hFF, 72'd0); ib(); tick();
        chk("R7 hold", rdata_a, refm[20]);

        // R3 R8: pipelined output
        ia(); ib(); tick();
        a_pipe = 1;
        pa(0, 1, 0, 1, 0, 0, 6'd10, 8'hFF, 72'd0); ib(); tick();
        chk("R3 pipelined not yet", rdata_a, 72'd0);
        ia(); tick();
        chk("R8 deselect still shows data", rdata_a, refm[10]);
        pa(0, 1, 0, 1, 0, 0, 6'd11, 8'hFF, 72'd0); tick();
        chk("R8 deselect visible after two edges", rdata_a, 72'd0);
        pa(0, 1, 0, 1, 0, 0, 6'd11, 8'h01, 72'd0); tick();
        chk("R3 pipelined full word", rdata_a, refm[11]);
        ia(); tick();
        chk("R8 lane change one edge late", rdata_a, msk(refm[11], 8'h01));
        ia(); tick();
        chk("R3 pipelined drains", rdata_a, 72'd0);
        a_pipe = 0;

        // R9: sleep
        rd_a("R9 before sleep", 6'd12, 8'hFF);
        a_slp = 1;
        pa(0, 1, 1, 1, 0, 0, 6'd30, 8'hFF, pat(30, 99)); ib(); tick();
        chk("R9 no access while asleep", rdata_a, 72'd0);
        pa(0, 1, 0, 0, 1, 1, 6'd0, 8'hFF, 72'd0); ib(); tick();
        a_slp = 0;
        pa(0, 1, 0, 0, 0, 0, 6'd0, 8'hFF, 72'd0); ib(); tick();
        chk("R9 address held in sleep", rdata_a, refm[12]);
        rd_a("R9 sleeping write ignored", 6'd30, 8'hFF);

        // R10: output enable
        a_oe = 0;
        pa(0, 1, 0, 1, 0, 0, 6'd12, 8'hFF, 72'd0); ib(); tick();
        chk("R10 oe low zero", rdata_a, 72'd0);
        a_oe = 1;
        pa(0, 1, 0, 0, 0, 0, 6'd0, 8'hFF, 72'd0); ib(); tick();
        chk("R10 state untouched", rdata_a, refm[12]);

        // R12: collision flag
        ia(); ib(); tick();
        pa(0, 1, 1, 1, 0, 0, 6'd40, 8'hFF, pat(40, 5));
        pb(0, 1, 0, 1, 0, 0, 6'd40, 8'hFF, 72'd0); tick();
        refm[40] = pat(40, 5);
        chk("R12 not before", {71'd0, coll_a}, 72'd0);
        ia(); ib(); tick();
        chk("R12 flag A", {71'd0, coll_a}, 72'd1);
        chk("R12 flag B", {71'd0, coll_b}, 72'd1);
        tick();
        chk("R12 one cycle", {70'd0, coll_a, coll_b}, 72'd0);
        pa(0, 1, 0, 1, 0, 0, 6'd40, 8'hFF, 72'd0);
        pb(0, 1, 0, 1, 0, 0, 6'd40, 8'hFF, 72'd0); tick();
        ia(); ib(); tick();
        chk("R12 read-read no flag", {70'd0, coll_a, coll_b}, 72'd0);

        // R13: disjoint lanes, same word, same cycle
        pa(0, 1, 1, 1, 0, 0, 6'd41, 8'h0F, pat(41, 6));
        pb(0, 1, 1, 1, 0, 0, 6'd41, 8'hF0, pat(41, 8)); tick();
        refm[41] = mrg(mrg(refm[41], pat(41, 6), 8'h0F), pat(41, 8), 8'hF0);
        rd_a("R13 merged word", 6'd41, 8'hFF);
        ia(); ib(); tick();

        // Random traffic: R2 R4 R11
        for (int k = 0; k < 400; k++) begin
            int oa, ob;
            logic [5:0] xa, xb;
            logic [7:0] la, lb;
            logic [71:0] da, db, ea, eb;
            oa = int'($urandom_range(3)); ob = int'($urandom_range(3));
            xa = 6'($urandom); xb = 6'($urandom);
            la = 8'($urandom); lb = 8'($urandom);
            da = 72'({$urandom, $urandom, $urandom});
            db = 72'({$urandom, $urandom, $urandom});
            if ((oa == 2 || ob == 2) && xa == xb) xb = xb + 6'd1;
            pa(oa == 3, oa != 0, oa >= 2, 1, 0, 0, xa, la, da);
            pb(ob == 3, ob != 0, ob >= 2, 1, 0, 0, xb, lb, db);
            tick();
            ea = (oa == 1) ? msk(refm[xa], la) : 72'd0;
            eb = (ob == 1) ? msk(refm[xb], lb) : 72'd0;
            chk("R11 random A", rdata_a, ea);
            chk("R11 random B", rdata_b, eb);
            chk("R12 random no flag", {70'd0, coll_a, coll_b}, 72'd0);
            if (oa == 2) refm[xa] = mrg(refm[xa], da, la);
            if (ob == 2) refm[xb] = mrg(refm[xb], db, lb);
        end

        w = 72'd0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err + int'(w[0]));
        $finish;
    end

endmodule